// File: doc/BRIEF.md
# Serially Loaded Reference Divider with Standby

This block takes a 24-bit control word over a three-wire serial port (shift clock, data and latch strobe) and sends it to the reference-divider register when the word is addressed there. The stored 16-bit ratio N sets the period of a one-cycle reference comparison pulse: one pulse every N cycles of the reference clock `clk`. A second stored bit sets the lock-detect output mode. A small phase/frequency detector compares this pulse with an external feedback pulse. It drives a tri-state charge output and a lock-detect flag.

All inputs are synchronous to `clk`. The serial port lines are sampled, and their rising edges are found, in that clock domain. An active-high operate input `oper` puts the block in standby when low. In standby the divider and the detector are held cleared, the charge output is released, and lock-detect reads low. The stored ratio and mode are kept, and the serial port can still load new words. `fb_rst` tells the external feedback divider to stay in reset during standby.

Top module: `refdiv_serial`

## Requirements
- R1: The word is shifted MSB first, one bit per rising edge of `ser_clk`. After 24 shifts the first bit sent is word bit 23. Word bits [23:8] are the ratio (bit 23 weighted 2^15), [7:5] are spare, [4] is the lock mode, [3:2] are test bits and [1:0] are the select code.
- R2: A rising edge of `ser_le` loads the ratio and mode only when the select code is 01, the test bits are 00 and the spare bits are 000. Any other word leaves the stored ratio and mode unchanged.
- R3: A loaded ratio below 5 (0 to 4) is stored as 5.
- R4: While `oper` is high, `ref_pulse` is high for exactly one cycle every N clock cycles, for any N from 5 to 65535.
- R5: A ratio loaded mid-count does not disturb the running period. The interval in progress still uses the old N, and the new N applies from the next terminal count.
- R6: While `oper` is low, `ref_pulse` stays low, the divider count is held at zero and `fb_rst` is high.
- R7: While `oper` is low, `cp_oe` and `lock_det` are low and the detector state is cleared. After release, no pending up or down error survives.
- R8: The stored ratio survives standby. After `oper` returns high, the first `ref_pulse` comes N-1 cycles later and then repeats every N cycles.
- R9: When the stored mode bit is 1, `lock_det` is high whenever the block is operating and no phase error is pending. When the mode bit is 0, `lock_det` stays low.
- R10: After reset the stored ratio is 5, the mode bit is 0, and `cp_oe` and `lock_det` are low.
- R11: A reference pulse with no feedback pulse yet makes `cp_oe` high with `cp_out` = 1. A feedback pulse first makes `cp_oe` high with `cp_out` = 0. Once both have arrived, the error clears and `cp_oe` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also samples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (rising edge shifts) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe (rising edge loads) |
| oper | input | 1 | High: operate, low: standby |
| fb_pulse | input | 1 | Feedback divider comparison pulse |
| ref_pulse | output | 1 | One-cycle reference comparison pulse |
| fb_rst | output | 1 | Holds the external feedback divider in reset |
| cp_out | output | 1 | Charge output: 1 up, 0 down, z when idle |
| cp_oe | output | 1 | High while cp_out is driven |
| lock_det | output | 1 | Lock-detect flag |

## Verification
Ratios 0 and 3 must come out as period 5. A design that skipped the clamp would hang or emit pulses every one to four cycles. Words with the wrong select code or nonzero test or spare bits must leave the period unchanged, and a design that loaded them would show a new period. A ratio loaded mid-interval must not shorten that interval: premature reload would cut the 144-cycle gap down to 20. Standby is checked for tri-state, low lock and no pulses, then for retained ratio and a cleared detector on release. The 65535 ratio catches counters that are one bit too narrow or off by one at the top of the range.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CNT_W     = 16;
  localparam int MIN_RATIO = 5;
  localparam logic [1:0] SEL_REF = 2'b01;

  // field order follows shift order: first bit in lands in count[MSB]
  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [2:0]       spare;
    logic             ld_on;
    logic [1:0]       tst;
    logic [1:0]       sel;
  } ctl_word_t;

  localparam int WORD_W = $bits(ctl_word_t);

  function automatic logic [CNT_W-1:0] clamp_ratio(input logic [CNT_W-1:0] raw);
    return (32'(raw) < MIN_RATIO) ? CNT_W'(MIN_RATIO) : raw;
  endfunction

  function automatic logic is_terminal(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] n);
    return cnt == (n - CNT_W'(1));
  endfunction

  function automatic logic word_for_ref(input ctl_word_t w);
    return (w.sel == SEL_REF) && (w.tst == 2'b00) && (w.spare == 3'b000);
  endfunction
endpackage

// File: rtl/refdiv_serial_rx.sv
module refdiv_serial_rx
  import refdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  output logic             load_take,
  output logic [CNT_W-1:0] ratio_q,
  output logic             ld_mode_q
);
  localparam int LINES = 2;  // 0: shift clock, 1: latch strobe

  logic [LINES-1:0] lvl_q, lvl_d, rise;
  logic             dat_q;
  ctl_word_t        shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      lvl_d <= '0;
      dat_q <= 1'b0;
    end else begin
      lvl_q <= {ser_le, ser_clk};
      lvl_d <= lvl_q;
      dat_q <= ser_dat;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    assign rise[i] = lvl_q[i] & ~lvl_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shreg <= '0;
    else if (rise[0]) shreg <= ctl_word_t'({shreg[WORD_W-2:0], dat_q});
  end

  assign load_take = rise[1] && word_for_ref(shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= CNT_W'(MIN_RATIO);
      ld_mode_q <= 1'b0;
    end else if (load_take) begin
      ratio_q   <= clamp_ratio(shreg.count);
      ld_mode_q <= shreg.ld_on;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oper,
  input  logic [CNT_W-1:0] ratio_q,
  output logic             term,
  output logic             ref_pulse,
  output logic [CNT_W-1:0] act_ratio,
  output logic [CNT_W-1:0] ref_cnt
);
  assign term      = is_terminal(ref_cnt, act_ratio);
  assign ref_pulse = oper & term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt   <= '0;
      act_ratio <= CNT_W'(MIN_RATIO);
    end else if (!oper || term) begin
      ref_cnt   <= '0;
      act_ratio <= ratio_q;
    end else begin
      ref_cnt   <= ref_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/refdiv_phase_det.sv
module refdiv_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic oper,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic ld_mode,
  output logic cp_out,
  output logic cp_oe,
  output logic lock_det,
  output logic err_pend
);
  logic up_q, dn_q, up_n, dn_n;

  assign up_n = up_q | ref_pulse;
  assign dn_n = dn_q | fb_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (!oper || (up_n && dn_n)) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  assign err_pend = up_q | dn_q;
  assign cp_oe    = oper & err_pend;
  assign cp_out   = cp_oe ? up_q : 1'bz;
  assign lock_det = oper & ld_mode & ~err_pend;
endmodule

// File: rtl/refdiv_serial.sv
module refdiv_serial
  import refdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_le,
  input  logic oper,
  input  logic fb_pulse,
  output logic ref_pulse,
  output logic fb_rst,
  output logic cp_out,
  output logic cp_oe,
  output logic lock_det
);
  logic             load_take, ld_mode_q, term, err_pend;
  logic [CNT_W-1:0] ratio_q, act_ratio, ref_cnt;

  refdiv_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .load_take(load_take), .ratio_q(ratio_q),
    .ld_mode_q(ld_mode_q)
  );

  refdiv_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .oper(oper), .ratio_q(ratio_q),
    .term(term), .ref_pulse(ref_pulse), .act_ratio(act_ratio),
    .ref_cnt(ref_cnt)
  );

  refdiv_phase_det u_pd (
    .clk(clk), .rst_n(rst_n), .oper(oper), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .ld_mode(ld_mode_q), .cp_out(cp_out),
    .cp_oe(cp_oe), .lock_det(lock_det), .err_pend(err_pend)
  );

  assign fb_rst = ~oper;
endmodule

// File: rtl/refdiv_serial_chk.sv
module refdiv_serial_chk
  import refdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             oper,
  input logic             ref_pulse,
  input logic             cp_oe,
  input logic             lock_det,
  input logic             load_take,
  input logic             term,
  input logic             err_pend,
  input logic [CNT_W-1:0] ratio_q,
  input logic             ld_mode_q,
  input logic [CNT_W-1:0] act_ratio,
  input logic [CNT_W-1:0] ref_cnt
);
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  p_ratio_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ratio_q) >= MIN_RATIO);

  p_ignore_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_take |=> $stable(ratio_q) && $stable(ld_mode_q));

  p_reload_at_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oper && !term) |=> $stable(act_ratio));

  p_standby_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oper |=> (ref_cnt == '0));

  p_standby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oper |-> !cp_oe && !lock_det && !ref_pulse);

  p_standby_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oper |=> !err_pend);
endmodule

bind refdiv_serial refdiv_serial_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oper(oper), .ref_pulse(ref_pulse),
  .cp_oe(cp_oe), .lock_det(lock_det), .load_take(load_take), .term(term),
  .err_pend(err_pend), .ratio_q(ratio_q), .ld_mode_q(ld_mode_q),
  .act_ratio(act_ratio), .ref_cnt(ref_cnt)
);

// File: tb/refdiv_serial_bench.sv
module refdiv_serial_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic oper = 1'b1, fb_pulse = 1'b0;
  logic ref_pulse, fb_rst, cp_out, cp_oe, lock_det;

  int  total = 0, bad = 0;
  longint cyc = 0;
  bit  done = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  refdiv_serial u_refdiv_serial (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .oper(oper), .fb_pulse(fb_pulse),
    .ref_pulse(ref_pulse), .fb_rst(fb_rst), .cp_out(cp_out),
    .cp_oe(cp_oe), .lock_det(lock_det)
  );

  typedef struct packed {
    logic [23:0] w;
    logic [16:0] per;
  } vec_t;

  // word = {ratio[15:0], spare[2:0], mode, test[1:0], select[1:0]}
  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{ {16'd144, 3'b000, 1'b1, 2'b00, 2'b01}, 17'd144 },
    '{ {16'd5,   3'b000, 1'b0, 2'b00, 2'b01}, 17'd5   },
    '{ {16'd3,   3'b000, 1'b0, 2'b00, 2'b01}, 17'd5   },
    '{ {16'd1000,3'b000, 1'b0, 2'b00, 2'b10}, 17'd5   },
    '{ {16'd1000,3'b000, 1'b0, 2'b00, 2'b01}, 17'd1000},
    '{ {16'd0,   3'b000, 1'b0, 2'b00, 2'b01}, 17'd5   },
    '{ {16'd200, 3'b000, 1'b0, 2'b00, 2'b00}, 17'd5   },
    '{ {16'd6,   3'b000, 1'b0, 2'b00, 2'b11}, 17'd5   },
    '{ {16'd6,   3'b000, 1'b0, 2'b00, 2'b01}, 17'd6   },
    '{ {16'd300, 3'b000, 1'b0, 2'b01, 2'b01}, 17'd6   },
    '{ {16'd300, 3'b100, 1'b0, 2'b00, 2'b01}, 17'd6   },
    '{ {16'd7,   3'b000, 1'b0, 2'b00, 2'b01}, 17'd7   }
  };

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_dat = w[i];
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (2) @(negedge clk);
    ser_le = 1'b1;
    repeat (2) @(negedge clk);
    ser_le = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // returns the cycle stamp of the pulse; leaves one negedge after it
  task automatic wait_pulse(output longint t);
    while (ref_pulse !== 1'b1) @(negedge clk);
    t = cyc;
    @(negedge clk);
    chk("R4 pulse width one cycle", ref_pulse, 0);
  endtask

  task automatic standby_release(output longint t_rel);
    oper = 1'b0;
    repeat (3) @(negedge clk);
    oper = 1'b1;
    t_rel = cyc;
  endtask

  initial begin : watchdog
    while (cyc < 195000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    longint ta, tb, tc, tr;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cp_oe after reset", cp_oe, 0);
    chk("R10 lock_det after reset", lock_det, 0);
    chk("R6 fb_rst while operating", fb_rst, 0);
    wait_pulse(ta);
    wait_pulse(tb);
    chk("R10 default period", tb - ta, 5);

    // table: R1 R2 R3 R8
    for (int k = 0; k < NV; k++) begin
      send_word(VT[k].w);
      standby_release(tr);
      wait_pulse(ta);
      chk($sformatf("R8 first pulse latency vec%0d", k), ta - tr, VT[k].per - 1);
      wait_pulse(tb);
      chk($sformatf("R1/R2/R3 period vec%0d", k), tb - ta, VT[k].per);
    end

    // R5: reload only at terminal count
    send_word({16'd144, 3'b000, 1'b0, 2'b00, 2'b01});
    standby_release(tr);
    wait_pulse(ta);
    send_word({16'd20, 3'b000, 1'b0, 2'b00, 2'b01});
    wait_pulse(tb);
    chk("R5 interval in progress keeps old ratio", tb - ta, 144);
    wait_pulse(tc);
    chk("R5 new ratio after terminal", tc - tb, 20);

    // R9 R11 R7 R6: detector and standby, mode bit 1
    send_word({16'd40, 3'b000, 1'b1, 2'b00, 2'b01});
    standby_release(tr);
    @(negedge clk);
    chk("R9 lock high when idle, mode 1", lock_det, 1);
    chk("R11 idle cp_oe", cp_oe, 0);
    wait_pulse(ta);
    chk("R11 ref first cp_oe", cp_oe, 1);
    chk("R11 ref first cp_out up", cp_out, 1);
    chk("R9 lock low on error", lock_det, 0);
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    chk("R11 error cleared cp_oe", cp_oe, 0);
    chk("R9 lock back high", lock_det, 1);
    @(negedge clk);
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    chk("R11 fb first cp_oe", cp_oe, 1);
    chk("R11 fb first cp_out down", cp_out, 0);
    oper = 1'b0;
    @(negedge clk);
    chk("R7 standby cp_oe", cp_oe, 0);
    chk("R7 standby lock_det", lock_det, 0);
    chk("R6 standby fb_rst", fb_rst, 1);
    seen = 0;
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (ref_pulse) seen++;
      @(negedge clk);
    end
    chk("R6 no pulse in standby", seen, 0);
    oper = 1'b1;
    tr = cyc;
    @(negedge clk);
    chk("R7 error cleared after release", cp_oe, 0);
    chk("R7 lock after release", lock_det, 1);
    wait_pulse(ta);
    chk("R8 ratio 40 kept through standby", ta - tr, 39);

    // R9 mode bit 0
    send_word({16'd40, 3'b000, 1'b0, 2'b00, 2'b01});
    standby_release(tr);
    @(negedge clk);
    chk("R9 lock low with mode 0", lock_det, 0);
    chk("R9 idle cp_oe mode 0", cp_oe, 0);

    // R4 upper bound 65535
    send_word({16'hFFFF, 3'b000, 1'b0, 2'b00, 2'b01});
    standby_release(tr);
    wait_pulse(ta);
    chk("R4 ratio 65535 latency", ta - tr, 65534);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule